// File: doc/BRIEF.md
# Alternating-Pulse Frame Validity Checker

This block listens to a two-wire sensor/actuator fieldbus after the analog front end has turned the line into discrete pulse events. It works on a grid of half-bit slots. On each slot tick it sees whether a pulse occurred and, if so, its polarity. From these events it rebuilds one frame: either a long master request or a short slave response. It then declares the frame good or bad.

Line coding works as follows. Every bit carries a pulse at its centre. A positive centre pulse means 1 and a negative centre pulse means 0. An extra pulse sits on the boundary between two equal neighbouring bits, so that polarity always alternates along a correct frame. The checker locks onto the first negative pulse and takes that pulse as the centre of the start bit. It collects the information bits and confirms even parity. It then watches a quiet window after the end bit. If every test holds, it raises a one-cycle good strobe together with the payload. Otherwise it reports the first fault it found as a 3-bit code and drops back to idle.

The slot tick is a clock enable, so the logic does not depend on the system clock frequency. The frame type is sampled once, together with the start pulse.

Top module: `apm_frame_checker`

## Requirements
- R1: `frame_kind` is sampled on the tick that carries the start pulse: 0 selects a 14-bit request and 1 selects a 7-bit response. Changing it later in the frame has no effect.
- R2: Bit k of a frame (k=0 is the start bit) is decided by the pulse in relative slot 2k, counting the start pulse as slot 0: positive means 1 and negative means 0. The payload holds the bits between the start bit and the parity bit, which is the second-to-last bit, with the first received bit as MSB and right-aligned in `payload` (11 bits for a request, 4 for a response, upper bits zero).
- R3: A correct frame gives `frame_ok` high for exactly one clock with `payload` valid. The strobe comes one clock after the tick of the last quiet slot.
- R4: A positive pulse seen while idle raises `frame_err` with code 1 (start fault).
- R5: A pulse whose polarity equals that of the previous pulse in the frame gives code 2 (alternation fault).
- R6: A bit-centre slot with no pulse gives code 3 (missing information).
- R7: If the bits from slot 2 through the parity bit hold an odd number of ones, the result is code 4 (parity fault).
- R8: A negative pulse at the end-bit centre gives code 5 (end fault). It is tested before parity.
- R9: After the end bit there is a quiet window of 5 slots for a request and 2 slots for a response. Any pulse inside it gives code 6 (length fault). A pulse on the slot after the window is treated as idle activity.
- R10: Only the first fault of a frame is reported. Each strobe returns the checker to idle. `frame_ok` and `frame_err` are never high together, and both are low after reset.
- R11: Nothing advances without `slot_tick`. Line inputs on cycles without a tick are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | Half-bit slot enable |
| line_ev | input | 1 | A pulse occurred in this slot |
| line_pos | input | 1 | Polarity of the pulse, 1 = positive |
| frame_kind | input | 1 | 0 = request framing, 1 = response framing |
| frame_ok | output | 1 | One-cycle good-frame strobe |
| payload | output | 11 | Decoded information bits, right-aligned |
| frame_err | output | 1 | One-cycle bad-frame strobe |
| err_code | output | 3 | Fault class, valid with `frame_err` |

## Verification
The assertions assume the front end reports at most one pulse per slot. They also assume that `line_ev` and `line_pos` matter only in a cycle where `slot_tick` is high, and that the tick never comes on two clocks in a row. The stimulus gives a tick every fourth clock and drives random values on the line inputs in the cycles between ticks. Each faulty frame is cut off right after the slot where its fault appears, so that leftover pulses are not taken as a new frame. The one exception is the case that deliberately places a pulse just past the quiet window.

// File: rtl/apm_frame_checker.sv
module apm_frame_checker #(
  parameter int REQ_BITS  = 14,
  parameter int RSP_BITS  = 7,
  parameter int REQ_QUIET = 5,
  parameter int RSP_QUIET = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_tick,
  input  logic                line_ev,
  input  logic                line_pos,
  input  logic                frame_kind,
  output logic                frame_ok,
  output logic [REQ_BITS-4:0] payload,
  output logic                frame_err,
  output logic [2:0]          err_code
);
  localparam int PAY_W = REQ_BITS - 3;
  localparam int CNT_W = $clog2(2 * REQ_BITS + 1);
  localparam int QW    = $clog2(REQ_QUIET + RSP_QUIET + 1);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_QUIET} st_t;

  st_t              st;
  logic [CNT_W-1:0] slot_idx;
  logic [QW-1:0]    qcnt;
  logic             kind_q, last_pos, par_acc;
  logic [PAY_W-1:0] shreg;
  logic [2:0]       fault;

  wire [CNT_W-1:0] end_idx  = kind_q ? CNT_W'(2 * (RSP_BITS - 1)) : CNT_W'(2 * (REQ_BITS - 1));
  wire [CNT_W-1:0] par_idx  = end_idx - CNT_W'(2);
  wire [QW-1:0]    q_last   = kind_q ? QW'(RSP_QUIET - 1) : QW'(REQ_QUIET - 1);
  wire             center   = ~slot_idx[0];
  wire             at_end   = (slot_idx == end_idx);
  wire             same_pol = line_ev && (line_pos == last_pos);

  assign payload = shreg;

  always_comb begin
    fault = 3'd0;
    if (slot_tick) begin
      case (st)
        S_IDLE:  if (line_ev && line_pos) fault = 3'd1;
        S_BITS:
          if (center) begin
            if (!line_ev)                 fault = 3'd3;
            else if (same_pol)            fault = 3'd2;
            else if (at_end && !line_pos) fault = 3'd5;
            else if (at_end && par_acc)   fault = 3'd4;
          end else if (same_pol) begin
            fault = 3'd2;
          end
        S_QUIET: if (line_ev) fault = 3'd6;
        default: fault = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      slot_idx  <= '0;
      qcnt      <= '0;
      kind_q    <= 1'b0;
      last_pos  <= 1'b0;
      par_acc   <= 1'b0;
      shreg     <= '0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      err_code  <= 3'd0;
    end else begin
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      if (fault != 3'd0) begin
        st        <= S_IDLE;
        frame_err <= 1'b1;
        err_code  <= fault;
      end else if (slot_tick) begin
        case (st)
          S_IDLE:
            if (line_ev) begin
              st       <= S_BITS;
              kind_q   <= frame_kind;
              last_pos <= 1'b0;
              slot_idx <= CNT_W'(1);
              par_acc  <= 1'b0;
              shreg    <= '0;
            end
          S_BITS: begin
            slot_idx <= slot_idx + CNT_W'(1);
            if (line_ev) last_pos <= line_pos;
            if (center && at_end) begin
              st   <= S_QUIET;
              qcnt <= '0;
            end else if (center) begin
              par_acc <= par_acc ^ line_pos;
              if (slot_idx != par_idx) shreg <= {shreg[PAY_W-2:0], line_pos};
            end
          end
          S_QUIET:
            if (qcnt == q_last) begin
              st       <= S_IDLE;
              frame_ok <= 1'b1;
            end else begin
              qcnt <= qcnt + QW'(1);
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_err));

  // R10
  ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  // R10
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (err_code >= 3'd1 && err_code <= 3'd6));

  // R4
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && err_code == 3'd1) |-> $past(slot_tick && line_ev && line_pos && st == S_IDLE));

  // R9
  length_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && err_code == 3'd6) |-> $past(st == S_QUIET && line_ev));

  // R3
  ok_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(st == S_QUIET && slot_tick && !line_ev));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> ($stable(st) && $stable(shreg) && !frame_ok && !frame_err));
endmodule

// File: tb/apm_frame_checker_tb.sv
module apm_frame_checker_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, slot_tick, line_ev, line_pos, frame_kind;
  logic        frame_ok, frame_err;
  logic [10:0] payload;
  logic [2:0]  err_code;

  apm_frame_checker dut_i (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .line_ev(line_ev),
    .line_pos(line_pos), .frame_kind(frame_kind), .frame_ok(frame_ok),
    .payload(payload), .frame_err(frame_err), .err_code(err_code));

  int checks = 0;
  int errors = 0;
  logic ev_a[64];
  logic pol_a[64];
  bit    exp_is_err[$];
  int    exp_val[$];
  string exp_req[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exp_ok(input int pay, input string req);
    exp_is_err.push_back(1'b0); exp_val.push_back(pay); exp_req.push_back(req);
  endtask

  task automatic exp_err(input int code, input string req);
    exp_is_err.push_back(1'b1); exp_val.push_back(code); exp_req.push_back(req);
  endtask

  task automatic build(input logic [13:0] bits, input int n);
    logic prev;
    for (int i = 0; i < 64; i++) begin ev_a[i] = 1'b0; pol_a[i] = 1'b0; end
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = bits[n-1-i];
      ev_a[2*i] = 1'b1; pol_a[2*i] = b;
      if (i > 0 && b == prev) begin ev_a[2*i-1] = 1'b1; pol_a[2*i-1] = ~b; end
      prev = b;
    end
  endtask

  task automatic play(input int len, input bit kind, input bit noise);
    for (int j = 0; j < len + 3; j++) begin
      @(negedge clk);
      slot_tick  = 1'b1;
      line_ev    = (j < len) ? ev_a[j] : 1'b0;
      line_pos   = (j < len) ? pol_a[j] : 1'b0;
      frame_kind = (j == 0) ? kind : ~kind;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        slot_tick = 1'b0;
        line_ev   = noise ? 1'($urandom) : 1'b0;
        line_pos  = noise ? 1'($urandom) : 1'b0;
      end
    end
  endtask

  function automatic logic [13:0] mk_req(input logic [10:0] p, input bit bad_par);
    return {1'b0, p, (^p) ^ bad_par, 1'b1};
  endfunction

  function automatic logic [13:0] mk_rsp(input logic [3:0] p, input bit end_bit);
    return {7'd0, 1'b0, p, ^p, end_bit};
  endfunction

  always @(negedge clk) begin
    if (rst_n && (frame_ok || frame_err)) begin
      chk(!(frame_ok && frame_err), "R10 both strobes", {frame_ok, frame_err}, 2);
      if (exp_is_err.size() == 0) begin
        chk(1'b0, "R10 unexpected strobe", {frame_ok, frame_err}, 0);
      end else begin
        bit    e_err;
        int    e_val;
        string e_req;
        e_err = exp_is_err.pop_front();
        e_val = exp_val.pop_front();
        e_req = exp_req.pop_front();
        chk(frame_err == e_err, e_req, {31'd0, frame_err}, {31'd0, e_err});
        if (!e_err) chk(int'(payload) == e_val, e_req, int'(payload), e_val);
        else        chk(int'(err_code) == e_val, e_req, int'(err_code), e_val);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; slot_tick = 1'b0; line_ev = 1'b0; line_pos = 1'b0; frame_kind = 1'b0;
    repeat (4) @(negedge clk);
    chk(!frame_ok && !frame_err, "R10 reset strobes", {frame_ok, frame_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R11: request with noise between ticks, kind flipped after start
    build(mk_req(11'h5A3, 1'b0), 14); exp_ok(11'h5A3, "R2 request payload"); play(32, 1'b0, 1'b1);
    build(mk_rsp(4'hB, 1'b1), 7);     exp_ok(4'hB, "R1 response payload");   play(15, 1'b1, 1'b1);
    build(mk_rsp(4'h0, 1'b1), 7);     exp_ok(4'h0, "R2 response zeros");     play(15, 1'b1, 1'b0);
    build(mk_rsp(4'hF, 1'b1), 7);     exp_ok(4'hF, "R2 response ones");      play(15, 1'b1, 1'b0);
    build(mk_req(11'h7FF, 1'b0), 14); exp_ok(11'h7FF, "R3 request ones");    play(32, 1'b0, 1'b0);
    build(mk_req(11'h000, 1'b0), 14); exp_ok(11'h000, "R3 request zeros");   play(32, 1'b0, 1'b1);

    // R4
    build(14'd0, 0); ev_a[0] = 1'b1; pol_a[0] = 1'b1;
    exp_err(1, "R4 start fault"); play(1, 1'b0, 1'b0);

    // R5: boundary pulse removed, then extra same-polarity pulse
    build(mk_req(11'h5A3, 1'b0), 14); ev_a[7] = 1'b0;
    exp_err(2, "R5 missing boundary"); play(9, 1'b0, 1'b0);
    build(mk_req(11'h5A3, 1'b0), 14); ev_a[1] = 1'b1; pol_a[1] = 1'b0;
    exp_err(2, "R5 extra pulse"); play(2, 1'b0, 1'b0);

    // R6
    build(mk_req(11'h5A3, 1'b0), 14); ev_a[4] = 1'b0;
    exp_err(3, "R6 missing centre"); play(5, 1'b0, 1'b0);

    // R7
    build(mk_req(11'h5A3, 1'b1), 14);
    exp_err(4, "R7 odd parity"); play(27, 1'b0, 1'b0);

    // R8
    build(mk_rsp(4'h6, 1'b0), 7);
    exp_err(5, "R8 negative end"); play(13, 1'b1, 1'b0);

    // R9
    build(mk_req(11'h2C5, 1'b0), 14); ev_a[29] = 1'b1; pol_a[29] = 1'b0;
    exp_err(6, "R9 request quiet pulse"); play(30, 1'b0, 1'b0);
    build(mk_rsp(4'h9, 1'b1), 7); ev_a[14] = 1'b1; pol_a[14] = 1'b0;
    exp_err(6, "R9 response last quiet slot"); play(15, 1'b1, 1'b0);
    build(mk_rsp(4'h9, 1'b1), 7); ev_a[15] = 1'b1; pol_a[15] = 1'b1;
    exp_ok(4'h9, "R9 window end ok"); exp_err(1, "R9 pulse after window");
    play(16, 1'b1, 1'b0);

    // R10: recovery after faults
    build(mk_req(11'h1E7, 1'b0), 14); exp_ok(11'h1E7, "R10 recovery"); play(32, 1'b0, 1'b0);

    repeat (20) @(negedge clk);
    chk(exp_is_err.size() == 0, "R3 missing strobes", exp_is_err.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule